// File: doc/BRIEF.md
# On-Chip Frame RAM Bus Slave

This block is a RAM slave on a simple command/response interconnect port, meant to hold video frames on their way to a display controller. Masters issue byte, halfword or word reads and writes at byte addresses inside a fixed window. Byte order is little-endian: each byte travels on the 32-bit data lane chosen by its address offset, and the slave writes only the addressed lanes. Every accepted non-idle beat gets exactly one response, one cycle after its command.

Multi-beat transfers must use incrementing addressing. The slave generates beat addresses itself from the first beat. Any illegal beat receives an error response and leaves the storage unchanged. Illegal beats are: an unknown command, an address outside the window, a misaligned halfword or word, an unsupported size, and any beat of a non-incrementing burst. Each error also sets a sticky status flag, which software clears by writing one to it.

The window starts at `BASE_ADDR` and spans `WIN_BYTES` bytes, a multiple of four that need not be a power of two. A full-size frame store sets `WIN_BYTES` to 256000, which covers 0x2000_0000 to 0x2003_E7FF. The default is a smaller window of the same shape.

Top module: `frame_ram_slave`

## Requirements
- R1: After reset, `rsp_code` is 0 (no response) and `err_flags` is 0.
- R2: A beat whose address lies in [`BASE_ADDR`, `BASE_ADDR`+`WIN_BYTES`) may succeed; a beat at any address outside that range gets an error response (`rsp_code` = 3) and changes no storage.
- R3: `req_cmd` codes are 0 idle, 1 write, 2 read. Idle produces no response (`rsp_code` = 0). Codes 3 to 7 get an error response and write nothing.
- R4: Size code 0 is a byte access: offset 0, 1, 2, 3 (address bits [1:0]) use data lanes [7:0], [15:8], [23:16], [31:24] respectively, and a byte write changes only that byte.
- R5: Size code 1 is a halfword access: offset 0 uses lanes [15:0] and offset 2 uses lanes [31:16], with the lower-addressed byte in the lower lane.
- R6: Size code 2 is a word access at offset 0 on all four lanes, with the byte at the lowest address on lanes [7:0].
- R7: A halfword at an odd offset, a word at a nonzero offset, or size code 3 gets an error response and writes nothing.
- R8: A successful beat gets `rsp_code` = 1 one cycle after its command. A read returns the addressed bytes on their lanes and zero on all other lanes. Writes and errors return `rsp_data` = 0.
- R9: A first beat with `req_len` > 1 and `req_seq` = 0 (incrementing) opens a burst of `req_len` beats. Each later beat uses the previous address plus the burst's access size in bytes. On later beats, `req_addr`, `req_size`, `req_len` and `req_seq` are ignored. Idle cycles inside a burst consume no beat. Each beat is checked against the window on its own.
- R10: A first beat with `req_len` > 1 and `req_seq` ≠ 0 (non-incrementing) gets an error response, as do all remaining beats of that burst, and none of them writes. With `req_len` ≤ 1 the sequence code is ignored.
- R11: `err_flags[3]` is set by every error response, appears in the same cycle as that response, and stays set until a cycle with `err_clr[3]` = 1 and no error beat. When an error beat and a clear arrive together, the flag stays set. `err_flags[2:0]` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_cmd | input | 3 | Command: 0 idle, 1 write, 2 read, others illegal |
| req_addr | input | 32 | Byte address (first beat only during a burst) |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_len | input | 4 | Burst beat count (0 or 1 means single) |
| req_seq | input | 2 | Burst addressing: 0 incrementing, others non-incrementing |
| req_wdata | input | 32 | Write data, bytes already on their lanes |
| rsp_code | output | 2 | 0 none, 1 success, 3 error |
| rsp_data | output | 32 | Read data on addressed lanes, other lanes zero |
| err_flags | output | 4 | Bit 3 is the sticky invalid-access flag |
| err_clr | input | 4 | Write-one-to-clear strobe for `err_flags` |

## Verification
The bench goes after the window edges: the last legal word, the first byte past the end, and an address just below the base. A comparator off by one there would either accept a beat it should reject or reject the last word. Every byte and halfword offset is written and read back on its lane, so a swapped lane or a byte enable that is too wide shows up as corrupted neighbour bytes. Misaligned beats, beats with unknown commands and beats of non-incrementing bursts all target locations with known contents. A design that still wrote on error would change data that the bench reads back afterwards. A burst with an idle gap, with junk on the ignored inputs, that runs off the window end catches a generator that counts idle cycles, follows `req_addr`, or stops checking the window after the first beat. Clearing the sticky flag, alone and in the same cycle as a new error, catches a wrong set/clear priority.

// File: rtl/frame_ram_pkg.sv
// Shared encodings for the frame RAM slave: command, size, response codes.
package frame_ram_pkg;
    localparam logic [2:0] CMD_IDLE  = 3'd0;
    localparam logic [2:0] CMD_WRITE = 3'd1;
    localparam logic [2:0] CMD_READ  = 3'd2;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [1:0] RSP_NONE = 2'd0;
    localparam logic [1:0] RSP_OK   = 2'd1;
    localparam logic [1:0] RSP_ERR  = 2'd3;

    localparam logic [1:0] SEQ_INCR = 2'd0;

    localparam int ERR_BIT = 3;
endpackage

// File: rtl/frame_ram_burst_gen.sv
// Burst address generator. On a first beat with a length above one it opens
// a burst and from then on supplies address and size for each non-idle beat,
// ignoring the request's address/size/len/seq. It assumes every non-idle
// command is accepted in the cycle it is presented (the slave never stalls).
module frame_ram_burst_gen
    import frame_ram_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_vld,
    input  logic [31:0]      in_addr,
    input  logic [1:0]       in_size,
    input  logic [LEN_W-1:0] in_len,
    input  logic [1:0]       in_seq,
    output logic [31:0]      cur_addr,
    output logic [1:0]       cur_size,
    output logic             cur_bad
);
    logic             active;
    logic [LEN_W-1:0] left;
    logic [31:0]      next_addr;
    logic [1:0]       bsize;
    logic             bad;
    logic             opens;

    // Decide whether this beat opens a new burst.
    always_comb opens = beat_vld && !active && (in_len > LEN_W'(1));

    // Select the beat's effective address, size and forced-error flag.
    always_comb begin
        if (active) begin
            cur_addr = next_addr;
            cur_size = bsize;
            cur_bad  = bad;
        end else begin
            cur_addr = in_addr;
            cur_size = in_size;
            cur_bad  = opens && (in_seq != SEQ_INCR);
        end
    end

    // Track the open burst: remaining beats, next address, poison flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            left      <= '0;
            next_addr <= '0;
            bsize     <= SZ_BYTE;
            bad       <= 1'b0;
        end else if (opens) begin
            active    <= 1'b1;
            left      <= in_len - LEN_W'(1);
            next_addr <= in_addr + (32'd1 << in_size);
            bsize     <= in_size;
            bad       <= (in_seq != SEQ_INCR);
        end else if (beat_vld && active) begin
            next_addr <= next_addr + (32'd1 << bsize);
            left      <= left - LEN_W'(1);
            if (left == LEN_W'(1)) active <= 1'b0;
        end
    end

    // R9
    burst_left_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (left != '0));
    // R9
    burst_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && beat_vld && left == LEN_W'(1)) |=> !active);
    // R9
    idle_holds_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !beat_vld) |=> (active && $stable(next_addr)));
endmodule

// File: rtl/frame_ram_access_check.sv
// Legality check for one beat: known command, address inside the window,
// supported size, natural alignment, no forced burst error. Also yields the
// word index and byte offset. Assumes WIN_BYTES is a multiple of four.
module frame_ram_access_check
    import frame_ram_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h2000_0000,
    parameter int unsigned WIN_BYTES = 6000,
    parameter int          IDX_W     = 11
) (
    input  logic [2:0]       cmd,
    input  logic [31:0]      addr,
    input  logic [1:0]       size,
    input  logic             force_bad,
    output logic             ok,
    output logic [IDX_W-1:0] word_idx,
    output logic [1:0]       byte_off
);
    logic [31:0] rel;
    logic        in_win;
    logic        cmd_ok;
    logic        aligned;

    // Offset from window base and window membership.
    always_comb begin
        rel    = addr - BASE_ADDR;
        in_win = (addr >= BASE_ADDR) && (rel < 32'(WIN_BYTES));
    end

    // Size/alignment legality and overall verdict.
    always_comb begin
        cmd_ok = (cmd == CMD_WRITE) || (cmd == CMD_READ);
        unique case (size)
            SZ_BYTE: aligned = 1'b1;
            SZ_HALF: aligned = (addr[0] == 1'b0);
            SZ_WORD: aligned = (addr[1:0] == 2'b00);
            default: aligned = 1'b0;
        endcase
        ok       = cmd_ok && in_win && aligned && !force_bad;
        word_idx = rel[IDX_W+1:2];
        byte_off = addr[1:0];
    end
endmodule

// File: rtl/frame_ram_lane_map.sv
// Maps access size and byte offset to the set of 32-bit data lanes used.
// Assumes the caller has already rejected misaligned or oversize beats.
module frame_ram_lane_map
    import frame_ram_pkg::*;
(
    input  logic [1:0] size,
    input  logic [1:0] byte_off,
    output logic [3:0] lanes
);
    // Little-endian lane selection.
    always_comb begin
        unique case (size)
            SZ_BYTE: lanes = 4'b0001 << byte_off;
            SZ_HALF: lanes = byte_off[1] ? 4'b1100 : 4'b0011;
            SZ_WORD: lanes = 4'b1111;
            default: lanes = 4'b0000;
        endcase
    end
endmodule

// File: rtl/frame_ram_slave.sv
// Frame RAM bus slave. Each non-idle beat is accepted in its cycle and
// answered one cycle later. Storage is one inferred synchronous byte bank per
// lane; storage has no reset. A sticky flag records invalid beats.
module frame_ram_slave
    import frame_ram_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h2000_0000,
    parameter int unsigned WIN_BYTES = 6000,
    parameter int          LEN_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       req_cmd,
    input  logic [31:0]      req_addr,
    input  logic [1:0]       req_size,
    input  logic [LEN_W-1:0] req_len,
    input  logic [1:0]       req_seq,
    input  logic [31:0]      req_wdata,
    output logic [1:0]       rsp_code,
    output logic [31:0]      rsp_data,
    output logic [3:0]       err_flags,
    input  logic [3:0]       err_clr
);
    localparam int WORDS = int'(WIN_BYTES / 4);
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int LANES = 4;

    logic             beat_vld;
    logic [31:0]      b_addr;
    logic [1:0]       b_size;
    logic             b_bad;
    logic             b_ok;
    logic [IDX_W-1:0] b_idx;
    logic [1:0]       b_off;
    logic [3:0]       b_lanes;
    logic [3:0]       wr_be;
    logic             rd_en;
    logic [31:0]      rd_q;
    logic [3:0]       rmask_q;
    logic             err_q;

    // A beat is any non-idle command.
    always_comb beat_vld = (req_cmd != CMD_IDLE);

    frame_ram_burst_gen #(.LEN_W(LEN_W)) i_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat_vld (beat_vld),
        .in_addr  (req_addr),
        .in_size  (req_size),
        .in_len   (req_len),
        .in_seq   (req_seq),
        .cur_addr (b_addr),
        .cur_size (b_size),
        .cur_bad  (b_bad)
    );

    frame_ram_access_check #(
        .BASE_ADDR (BASE_ADDR),
        .WIN_BYTES (WIN_BYTES),
        .IDX_W     (IDX_W)
    ) i_check (
        .cmd       (req_cmd),
        .addr      (b_addr),
        .size      (b_size),
        .force_bad (b_bad),
        .ok        (b_ok),
        .word_idx  (b_idx),
        .byte_off  (b_off)
    );

    frame_ram_lane_map i_lanes (
        .size     (b_size),
        .byte_off (b_off),
        .lanes    (b_lanes)
    );

    // Gate lane enables with the legality verdict.
    always_comb begin
        wr_be = (b_ok && req_cmd == CMD_WRITE) ? b_lanes : 4'b0000;
        rd_en = b_ok && (req_cmd == CMD_READ);
    end

    // One byte bank per lane; data is taken from its own lane.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_bank
        logic [7:0] bank [WORDS];

        // Byte write on this lane when enabled.
        always_ff @(posedge clk) begin
            if (wr_be[ln]) bank[b_idx] <= req_wdata[8*ln +: 8];
        end

        // Synchronous read of this lane for legal reads.
        always_ff @(posedge clk) begin
            if (rd_en) rd_q[8*ln +: 8] <= bank[b_idx];
        end

        // Zero lanes the read did not address.
        always_comb rsp_data[8*ln +: 8] = rd_q[8*ln +: 8] & {8{rmask_q[ln]}};
    end

    // Register the response code and the read lane mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_code <= RSP_NONE;
            rmask_q  <= 4'b0000;
        end else begin
            rsp_code <= !beat_vld ? RSP_NONE : (b_ok ? RSP_OK : RSP_ERR);
            rmask_q  <= rd_en ? b_lanes : 4'b0000;
        end
    end

    // Sticky invalid-access flag; a new error wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                err_q <= 1'b0;
        else if (beat_vld && !b_ok) err_q <= 1'b1;
        else if (err_clr[ERR_BIT])  err_q <= 1'b0;
    end

    always_comb err_flags = {err_q, 3'b000};

    // R3
    idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cmd == CMD_IDLE) |=> (rsp_code == RSP_NONE));
    // R3
    bad_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cmd > CMD_READ) |=> (rsp_code == RSP_ERR));
    // R2
    window_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_be != 4'b0000 || rd_en) |-> (b_addr >= BASE_ADDR));
    // R4
    lane_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_ok |-> ($countones(b_lanes) == (1 << b_size)));
    // R8
    quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code != RSP_OK) |-> (rsp_data == 32'd0));
    // R10
    poisoned_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_bad |-> (wr_be == 4'b0000));
    // R11
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code == RSP_ERR) |-> err_flags[ERR_BIT]);
    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags[ERR_BIT] && !err_clr[ERR_BIT]) |=> err_flags[ERR_BIT]);
endmodule

// File: tb/test_frame_ram_slave.sv
// Scoreboard bench: the driver task models each beat from the requirements
// and queues the expected response; a negedge monitor pops and compares.
module test_frame_ram_slave;
    localparam logic [31:0] BASE = 32'h2000_0000;
    localparam int unsigned WIN  = 6000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  req_cmd = 3'd0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [3:0]  req_len = '0;
    logic [1:0]  req_seq = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_data;
    logic [3:0]  err_flags;
    logic [3:0]  err_clr = '0;

    int checks = 0;
    int errors = 0;

    logic [1:0]  q_code [$];
    logic [31:0] q_data [$];
    string       q_tag  [$];
    logic [7:0]  mdl [int];

    bit          bb_active = 0;
    int          bb_left = 0;
    logic [31:0] bb_addr = '0;
    logic [1:0]  bb_size = '0;
    bit          bb_bad = 0;

    always #2.5 clk = ~clk;

    frame_ram_slave i_frame_ram_slave (
        .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_size(req_size), .req_len(req_len), .req_seq(req_seq),
        .req_wdata(req_wdata), .rsp_code(rsp_code), .rsp_data(rsp_data),
        .err_flags(err_flags), .err_clr(err_clr)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one beat at a negedge and queue its expected response.
    task automatic beat(string tag, logic [2:0] cmd, logic [31:0] addr,
                        logic [1:0] size, logic [3:0] len, logic [1:0] seq,
                        logic [31:0] wdata);
        logic [31:0] a;
        logic [1:0]  s;
        bit          bad, legal, in_win, algn;
        logic [31:0] exp_d;
        int          rel;
        req_cmd = cmd; req_addr = addr; req_size = size;
        req_len = len; req_seq = seq; req_wdata = wdata;
        if (cmd != 3'd0) begin
            if (bb_active) begin
                a = bb_addr; s = bb_size; bad = bb_bad;
                bb_addr = bb_addr + (32'd1 << bb_size);
                bb_left--;
                if (bb_left == 0) bb_active = 0;
            end else begin
                a = addr; s = size; bad = (len > 1) && (seq != 2'd0);
                if (len > 1) begin
                    bb_active = 1; bb_left = int'(len) - 1;
                    bb_addr = addr + (32'd1 << size); bb_size = size;
                    bb_bad = (seq != 2'd0);
                end
            end
            in_win = (a >= BASE) && (a - BASE < 32'(WIN));
            algn = (s == 2'd0) || (s == 2'd1 && a[0] == 1'b0) ||
                   (s == 2'd2 && a[1:0] == 2'b00);
            legal = (cmd == 3'd1 || cmd == 3'd2) && in_win && algn && !bad;
            exp_d = '0;
            rel = int'((a - BASE) & ~32'd3);
            if (legal) begin
                for (int l = 0; l < 4; l++) begin
                    if (l >= int'(a[1:0]) && l < int'(a[1:0]) + (1 << s)) begin
                        if (cmd == 3'd1) mdl[rel + l] = wdata[8*l +: 8];
                        else exp_d[8*l +: 8] = mdl.exists(rel + l) ? mdl[rel + l] : 8'hxx;
                    end
                end
            end
            q_code.push_back(legal ? 2'd1 : 2'd3);
            q_data.push_back(exp_d);
            q_tag.push_back(tag);
        end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        req_cmd = 3'd0; req_addr = 32'hBAD0_0BAD;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: every response must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && rsp_code != 2'd0) begin
            if (q_code.size() == 0) begin
                check("unexpected response R3", 32'(rsp_code), 32'd0);
            end else begin
                string t;
                logic [1:0] c;
                logic [31:0] d;
                t = q_tag.pop_front(); c = q_code.pop_front(); d = q_data.pop_front();
                check({t, " code"}, 32'(rsp_code), 32'(c));
                check({t, " data R8"}, rsp_data, d);
                if (c == 2'd3) check({t, " sticky R11"}, 32'(err_flags[3]), 32'd1);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rsp_code", 32'(rsp_code), 32'd0);
        check("R1 err_flags", 32'(err_flags), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 word write/read, R8 timing
        beat("R6 wr", 3'd1, BASE, 2'd2, 4'd1, 2'd0, 32'h4433_2211);
        beat("R6 rd", 3'd2, BASE, 2'd2, 4'd1, 2'd0, 32'h0);
        // R4 each byte lane
        for (int k = 0; k < 4; k++)
            beat("R4 wr", 3'd1, BASE + 32'd4 + 32'(k), 2'd0, 4'd0, 2'd0,
                 32'(8'hA0 + k) << (8*k));
        for (int k = 0; k < 4; k++)
            beat("R4 rd", 3'd2, BASE + 32'd4 + 32'(k), 2'd0, 4'd0, 2'd0, 32'h0);
        beat("R4 word", 3'd2, BASE + 32'd4, 2'd2, 4'd0, 2'd0, 32'h0);
        // R5 halfwords
        beat("R5 wr lo", 3'd1, BASE + 32'd8, 2'd1, 4'd0, 2'd0, 32'h0000_BEEF);
        beat("R5 wr hi", 3'd1, BASE + 32'd10, 2'd1, 4'd0, 2'd0, 32'hCAFE_0000);
        beat("R5 rd hi", 3'd2, BASE + 32'd10, 2'd1, 4'd0, 2'd0, 32'h0);
        beat("R5 rd lo", 3'd2, BASE + 32'd8, 2'd1, 4'd0, 2'd0, 32'h0);
        // R7 misaligned and oversize
        beat("R7 half odd", 3'd1, BASE + 32'd9, 2'd1, 4'd0, 2'd0, 32'hFFFF_FFFF);
        beat("R7 word off2", 3'd1, BASE + 32'd10, 2'd2, 4'd0, 2'd0, 32'hFFFF_FFFF);
        beat("R7 size3", 3'd1, BASE + 32'd8, 2'd3, 4'd0, 2'd0, 32'hFFFF_FFFF);
        beat("R7 unchanged", 3'd2, BASE + 32'd8, 2'd2, 4'd0, 2'd0, 32'h0);
        // R2 window edges
        beat("R2 last wr", 3'd1, BASE + 32'(WIN) - 32'd4, 2'd2, 4'd0, 2'd0, 32'h7766_5544);
        beat("R2 last rd", 3'd2, BASE + 32'(WIN) - 32'd4, 2'd2, 4'd0, 2'd0, 32'h0);
        beat("R2 past end", 3'd2, BASE + 32'(WIN), 2'd0, 4'd0, 2'd0, 32'h0);
        beat("R2 below base", 3'd1, BASE - 32'd4, 2'd2, 4'd0, 2'd0, 32'h0);
        // R3 illegal commands and idle
        beat("R3 cmd3", 3'd3, BASE, 2'd2, 4'd0, 2'd0, 32'hFFFF_FFFF);
        beat("R3 cmd7", 3'd7, BASE, 2'd2, 4'd0, 2'd0, 32'hFFFF_FFFF);
        idle(2);
        beat("R3 unchanged", 3'd2, BASE, 2'd2, 4'd0, 2'd0, 32'h0);
        // R11 clear alone
        err_clr = 4'b1000; idle(1); err_clr = 4'b0000;
        check("R11 cleared", 32'(err_flags), 32'd0);
        // R11 error and clear together: set wins
        err_clr = 4'b1000;
        beat("R11 set wins", 3'd5, BASE, 2'd2, 4'd0, 2'd0, 32'h0);
        err_clr = 4'b0000;
        idle(1);
        check("R11 stays set", 32'(err_flags), 32'h8);
        // R9 incrementing burst with idle gap and junk on ignored inputs
        beat("R9 bw0", 3'd1, BASE + 32'h100, 2'd2, 4'd4, 2'd0, 32'h1111_1111);
        idle(1);
        beat("R9 bw1", 3'd1, 32'hDEAD_0001, 2'd0, 4'd9, 2'd3, 32'h2222_2222);
        beat("R9 bw2", 3'd1, 32'h0, 2'd3, 4'd0, 2'd1, 32'h3333_3333);
        idle(2);
        beat("R9 bw3", 3'd1, 32'h1, 2'd1, 4'd2, 2'd0, 32'h4444_4444);
        beat("R9 br0", 3'd2, BASE + 32'h100, 2'd0, 4'd8, 2'd0, 32'h0);
        for (int k = 1; k < 8; k++)
            beat("R9 brk", 3'd2, 32'hFFFF_FFF0, 2'd2, 4'd1, 2'd2, 32'h0);
        beat("R9 after", 3'd2, BASE + 32'h10C, 2'd2, 4'd0, 2'd0, 32'h0);
        // R9 burst running past the window end
        beat("R9 edge0", 3'd1, BASE + 32'(WIN) - 32'd8, 2'd2, 4'd3, 2'd0, 32'hAAAA_0000);
        beat("R9 edge1", 3'd1, 32'h0, 2'd2, 4'd0, 2'd0, 32'hAAAA_0001);
        beat("R9 edge2", 3'd1, 32'h0, 2'd2, 4'd0, 2'd0, 32'hAAAA_0002);
        beat("R9 edge rd", 3'd2, BASE + 32'(WIN) - 32'd4, 2'd2, 4'd0, 2'd0, 32'h0);
        // R10 non-incrementing burst writes nothing
        for (int k = 0; k < 3; k++)
            beat("R10 pre", 3'd1, BASE + 32'h200 + 32'(4*k), 2'd2, 4'd0, 2'd0,
                 32'h5A5A_5A50 + 32'(k));
        beat("R10 b0", 3'd1, BASE + 32'h200, 2'd2, 4'd3, 2'd2, 32'hFFFF_FFFF);
        beat("R10 b1", 3'd1, BASE + 32'h204, 2'd2, 4'd0, 2'd0, 32'hFFFF_FFFF);
        beat("R10 b2", 3'd1, BASE + 32'h208, 2'd2, 4'd0, 2'd0, 32'hFFFF_FFFF);
        for (int k = 0; k < 3; k++)
            beat("R10 unchanged", 3'd2, BASE + 32'h200 + 32'(4*k), 2'd2, 4'd0, 2'd0, 32'h0);
        // R10 single beat ignores sequence code
        beat("R10 single seq", 3'd2, BASE + 32'h200, 2'd2, 4'd1, 2'd3, 32'h0);
        idle(3);
        check("R3 all responses seen", 32'(q_code.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule